// File: doc/BRIEF.md
# Chip-Select Serial ADC Output Port

This block models the digital side of an 18-bit serial converter in chip-select mode. It is synthesizable and serves as the device-side partner when a host serial controller is verified. The analog conversion is replaced in two ways. A parallel sample is captured on the convert-strobe rising edge, and a parameterised number of clock cycles stands in for the conversion time. All pins are sampled on the system clock. Every response appears right after the rising clock edge that samples the input change.

A convert rising edge taken while the select pin is high starts a conversion, and the data line stays released for the whole conversion. When the conversion ends, the result waits until the select pin falls. The MSB is then driven, and each falling edge of the serial clock steps the output one bit lower. The line is released on the 18th falling edge, or earlier if the select pin returns high. Several such devices can therefore share one data line. Each result can be read only once.

Top module: `adc_cs_port`

## Requirements
- R1: A rising edge of `cnv_i` sampled while `sdi_i` is high starts a conversion lasting `CONV_CYCLES` clocks. During the conversion `sdo_oe_o` is 0.
- R2: `sample_i` is captured at the edge that starts the conversion. Changes to it afterwards do not alter the bits read out.
- R3: While idle, when `cnv_i` and `sdi_i` are both sampled low, the next cycle shows `sdo_oe_o`=1 and `sdo_o`=0.
- R4: After the conversion completes, a falling edge on `sdi_i` gives `sdo_oe_o`=1 and `sdo_o` equal to bit 17 of the captured sample in the next cycle.
- R5: Each falling edge of `sck_i` during readback moves `sdo_o` to the next lower bit. Rising edges of `sck_i` leave it unchanged.
- R6: The 18th falling edge of `sck_i` sets `sdo_oe_o` to 0.
- R7: If `sdi_i` is sampled high during readback, `sdo_oe_o` is 0 in the next cycle.
- R8: If `sdi_i` is low when the conversion completes, the result is discarded, and a later `sdi_i` fall drives nothing. If `sdi_i` dips low in mid-conversion but is high again at completion, the result reads normally.
- R9: After a completed read or a read cut short, a further `sdi_i` fall with `cnv_i` high leaves `sdo_oe_o` at 0 until a new conversion.
- R10: A rising edge of `cnv_i` with `sdi_i` low starts nothing. A later `sdi_i` fall drives no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all pins sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Convert strobe |
| sdi_i | input | 1 | Serial input used as chip select |
| sck_i | input | 1 | Serial clock from host |
| sample_i | input | DATA_W | Parallel value standing in for the analog input |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Data output enable; 0 means high impedance |

## Verification
A wrong internal state shows up at `sdo_oe_o` or `sdo_o` one cycle after the input change that exposes it. A bit index that is off by one shows as a wrong bit on the first falling edge, and as the line released one edge early or late. A stale captured sample shows as wrong bits, because the bench alters `sample_i` right after the convert edge. A result that is not cleared after a read, or not dropped when the select pin is low at completion, shows as the output being enabled on a later select fall that should leave the line released.

// File: rtl/adc_cs_pkg.sv
package adc_cs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_READY = 2'd2,
    ST_SHIFT = 2'd3
  } port_state_e;
endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
  parameter int unsigned N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST_VAL[g];
      else         q <= sig_i[g];
    end
    assign level_o[g] = q;
    assign rise_o[g]  = sig_i[g] & ~q;
    assign fall_o[g]  = ~sig_i[g] & q;
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/adc_cs_port.sv
module adc_cs_port
  import adc_cs_pkg::*;
#(
  parameter int unsigned DATA_W      = 18,
  parameter int unsigned CONV_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnv_i,
  input  logic              sdi_i,
  input  logic              sck_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  // pin order: {sck, sdi, cnv}; sdi idles high
  logic [2:0] lvl, rise, fall;
  adc_edge_det #(.N(3), .RST_VAL(3'b010)) u_edge (
    .clk_i, .rst_ni,
    .sig_i  ({sck_i, sdi_i, cnv_i}),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  logic cnv_rise, sdi_fall, sck_fall;
  assign cnv_rise = rise[0];
  assign sdi_fall = fall[1];
  assign sck_fall = fall[2];

  port_state_e      st_q;
  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  idx_q;
  logic              conv_start, conv_busy, conv_done;

  assign conv_start = ((st_q == ST_IDLE) || (st_q == ST_READY)) && cnv_rise && sdi_i;

  adc_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .start_i(conv_start),
    .busy_o (conv_busy),
    .done_o (conv_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
      idx_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_READY: begin
          if (conv_start) begin
            data_q <= sample_i;
            st_q   <= ST_CONV;
          end else if (st_q == ST_READY && sdi_fall) begin
            idx_q <= TOP_IDX;
            st_q  <= ST_SHIFT;
          end
        end
        ST_CONV: begin
          // select low at completion: pin belongs to another device, drop result
          if (conv_done) st_q <= sdi_i ? ST_READY : ST_IDLE;
        end
        ST_SHIFT: begin
          if (sdi_i) st_q <= ST_IDLE;
          else if (sck_fall) begin
            if (idx_q == '0) st_q  <= ST_IDLE;
            else             idx_q <= idx_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic in_shift;
  assign in_shift = (st_q == ST_SHIFT);
  assign sdo_oe_o = in_shift || ((st_q == ST_IDLE) && !lvl[0] && !lvl[1]);
  assign sdo_o    = in_shift && data_q[idx_q];
endmodule

// File: rtl/adc_cs_port_chk.sv
module adc_cs_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cnv_i,
  input logic sdi_i,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic conv_busy,
  input logic in_shift,
  input logic in_idle,
  input logic sck_fall,
  input logic last_bit
);
  assert_quiet_conv_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_busy |-> !sdo_oe_o);

  assert_drive_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_idle && !cnv_i && !sdi_i) |=> (sdo_oe_o && !sdo_o));

  assert_hold_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_shift && !sck_fall && !sdi_i) |=> (sdo_oe_o && $stable(sdo_o)));

  assert_release_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_shift && !sdi_i && sck_fall && last_bit) |=> !sdo_oe_o);

  assert_release_cs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_shift && sdi_i) |=> !sdo_oe_o);

  assert_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({conv_busy, in_shift}));
endmodule

bind adc_cs_port adc_cs_port_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnv_i    (cnv_i),
  .sdi_i    (sdi_i),
  .sdo_o    (sdo_o),
  .sdo_oe_o (sdo_oe_o),
  .conv_busy(conv_busy),
  .in_shift (in_shift),
  .in_idle  (st_q == adc_cs_pkg::ST_IDLE),
  .sck_fall (sck_fall),
  .last_bit (idx_q == '0)
);

// File: tb/tb_adc_cs_port.sv
module tb_adc_cs_port;
  localparam int CLK_PERIOD  = 10;
  localparam int DATA_W      = 18;
  localparam int CONV_CYCLES = 8;

  logic clk = 0, rst_ni = 0;
  logic cnv = 0, sdi = 1, sck = 0;
  logic [DATA_W-1:0] sample = '0;
  logic sdo, sdo_oe;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_cs_port #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cnv_i(cnv), .sdi_i(sdi), .sck_i(sck),
    .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // low_mid: dip select low early; low_end: hold select low at completion
  task automatic convert(input logic [DATA_W-1:0] v, input bit low_mid, input bit low_end);
    cnv = 0; sdi = 1; tick();
    sample = v; cnv = 1; tick();
    sample = ~v;                        // R2: must not be seen
    for (int c = 0; c < CONV_CYCLES; c++) begin
      check("R1 oe during conversion", sdo_oe, 0);
      if (low_mid) sdi = (c == 1 || c == 2) ? 1'b0 : 1'b1;
      if (low_end && c == CONV_CYCLES - 1) sdi = 0;
      tick();
    end
  endtask

  task automatic read_bits(input logic [DATA_W-1:0] v, input int nbits);
    sdi = 0; tick();
    check("R4 oe after select fall", sdo_oe, 1);
    check("R4 R2 msb", sdo, v[DATA_W-1]);
    for (int k = 1; k < nbits; k++) begin
      sck = 1; tick();
      check("R5 rise holds bit", sdo, v[DATA_W-k]);
      sck = 0; tick();
      check("R5 R2 next bit", sdo, v[DATA_W-1-k]);
    end
  endtask

  task automatic full_read(input logic [DATA_W-1:0] v);
    read_bits(v, DATA_W);
    sck = 1; tick();
    check("R6 oe before last fall", sdo_oe, 1);
    sck = 0; tick();
    check("R6 released after last fall", sdo_oe, 0);
    sdi = 1; tick();
    sdi = 0; tick();
    check("R9 no second read", sdo_oe, 0);
    sdi = 1; tick();
  endtask

  initial begin
    repeat (2) tick();
    rst_ni = 1; tick();
    check("R3 reset state released", sdo_oe, 0);

    // R3: idle low drive
    sdi = 0; tick();
    check("R3 oe low drive", sdo_oe, 1);
    check("R3 data low", sdo, 0);
    // R10: convert edge with select low
    cnv = 1; tick();
    check("R10 released with cnv high", sdo_oe, 0);
    repeat (CONV_CYCLES + 2) tick();
    sdi = 1; tick(); sdi = 0; tick();
    check("R10 no data", sdo_oe, 0);
    sdi = 1; tick();

    // sweep: zeros, ones, walking ones, alternating
    convert('0, 0, 0); full_read('0);
    convert('1, 0, 0); full_read('1);
    for (int b = 0; b < DATA_W; b++) begin
      convert(DATA_W'(1) << b, 0, 0); full_read(DATA_W'(1) << b);
    end
    convert(18'h2AAAA, 0, 0); full_read(18'h2AAAA);
    convert(18'h15555, 0, 0); full_read(18'h15555);

    // R7, R9: cut short at several lengths
    for (int n = 1; n < DATA_W; n += 4) begin
      convert(18'h3C5A1 ^ DATA_W'(n), 0, 0);
      read_bits(18'h3C5A1 ^ DATA_W'(n), n);
      sdi = 1; tick();
      check("R7 released on select high", sdo_oe, 0);
      sdi = 0; tick();
      check("R9 no read after cut", sdo_oe, 0);
      sdi = 1; tick();
    end

    // R8: dip mid-conversion still readable
    convert(18'h1E0F3, 1, 0); full_read(18'h1E0F3);
    // R8: select low at completion drops result
    convert(18'h2B7C4, 0, 1);
    check("R8 nothing on held low", sdo_oe, 0);
    sdi = 1; tick(); sdi = 0; tick();
    check("R8 dropped result", sdo_oe, 0);
    sdi = 1; tick();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule